// File: doc/BRIEF.md
# Dual-Input RC-5 Biphase Receiver

This block takes two active-low infrared receiver lines and turns RC-5 biphase frames into binary words. Both lines idle high. Whichever line falls first, when the block is armed, becomes the owner of the frame. The other line is ignored until the frame completes or is thrown away, and the owner line has then been quiet long enough to re-arm the block. A static select pin decides whether the second line may carry standard frames at all. When the pin is low, that line is reserved for a different frame type that this block does not decode, so its activity is ignored.

All timing comes from the core clock, which is nominally 455 kHz. A half-bit lasts `HALF_CYC` clocks, 404 by default. The block measures every interval between level changes on the owner line. It rebuilds the 28 half-bit levels and checks each bit cell for a proper mid-bit transition. A frame is accepted only if every cell is good and both start bits are 1. An accepted frame is reported once, through a single-cycle strobe together with the toggle, address and command fields.

The output side has no back-pressure. There is no ready input and no buffer. The consumer must capture the fields in the cycle the strobe is high. The fields keep their value until the next accepted frame.

Top module: `rc5_dual_decoder`

## Requirements
- R1: When the block is armed, the first falling edge seen on an enabled line claims the frame, and line A wins a tie in the same cycle. Edges on the other line have no effect until the block re-arms.
- R2: Line B is enabled only while `b_std_sel` is 1. While `b_std_sel` is 0, line B's activity never starts a frame.
- R3: A frame has 14 bits, sent first to last as: start, start, toggle, address[4:0] MSB first, command[5:0] MSB first. On the active-low line a 1 is a low half followed by a high half, and a 0 is a high half followed by a low half.
- R4: Each accepted frame raises `word_valid` for exactly one cycle and updates `word_toggle`, `word_addr` and `word_cmd`. A rejected frame raises no strobe.
- R5: An interval between level changes counts as one half-bit if it lasts from 0.75 to 1.25 `HALF_CYC`, and as two half-bits if it lasts from 1.5 to 2.5 `HALF_CYC`. Any other interval aborts the frame.
- R6: A frame whose two start bits are not both 1 is rejected.
- R7: If the owner line stays low for more than 2.5 `HALF_CYC`, the frame is aborted.
- R8: After a frame is accepted or aborted, the block re-arms only once the owner line has been high without a break for 8 `HALF_CYC`. A frame that begins earlier is ignored as a whole.
- R9: After reset, `word_valid` is 0, all data outputs are 0 and the block is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, nominally 455 kHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_a_n | input | 1 | Line A, active-low, standard frames only |
| ir_b_n | input | 1 | Line B, active-low, standard frames when enabled |
| b_std_sel | input | 1 | 1 enables line B for standard frames |
| word_valid | output | 1 | Single-cycle strobe for an accepted frame |
| word_toggle | output | 1 | Toggle bit of the last accepted frame |
| word_addr | output | 5 | Address of the last accepted frame |
| word_cmd | output | 6 | Command of the last accepted frame |

## Verification
The bench targets the edges of the timing windows:
- Half-bits stretched to 0.8 and 1.2 of nominal must still decode. A design with narrow windows would drop these frames.
- Half-bits at 0.7 and 1.35 of nominal must be rejected. The 1.35 case falls in the gap between the single and double windows, so a design that treats that gap as a double would accept a damaged frame.
- A line held low too long must abort. A design without this check would hang waiting for an edge.

The bench also contests ownership:
- Overlapping frames on both lines, and a tie in the same cycle. A weak arbiter would mix the two lines into garbage or decode the losing frame.
- A frame sent too soon after the previous one. A design that re-arms early would pick up that frame in the middle.
- A frame with a bad start bit, and traffic on line B while it is disabled. A careless design would report either one.

// File: rtl/rc5_dec_pkg.sv
package rc5_dec_pkg;
  localparam int FRAME_BITS = 14;
  localparam int HALVES     = 2 * FRAME_BITS;

  typedef enum logic [1:0] {
    ST_ARMED,
    ST_RECV,
    ST_CHECK,
    ST_QUIET
  } dec_state_t;

  typedef struct packed {
    logic       toggle;
    logic [4:0] addr;
    logic [5:0] cmd;
  } rc5_word_t;
endpackage

// File: rtl/rc5_in_sync.sv
module rc5_in_sync #(
  parameter int N_IN   = 2,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_IN-1:0] pin_n,
  output logic [N_IN-1:0] lvl,
  output logic [N_IN-1:0] fall
);
  // Each lane: STAGES synchroniser flops plus one extra flop for edge detection.
  for (genvar g = 0; g < N_IN; g++) begin : g_lane
    logic [STAGES:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '1;
      else        sh <= {sh[STAGES-1:0], pin_n[g]};
    end

    assign lvl[g]  = sh[STAGES-1];
    assign fall[g] = sh[STAGES] & ~sh[STAGES-1];
  end
endmodule

// File: rtl/rc5_arbiter.sv
module rc5_arbiter #(
  parameter int N_IN = 2,
  localparam int IW  = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            armed,
  input  logic [N_IN-1:0] lane_en,
  input  logic [N_IN-1:0] fall,
  input  logic [N_IN-1:0] lvl,
  output logic            start,
  output logic [IW-1:0]   sel_idx,
  output logic            line
);
  logic [IW-1:0] pick;

  // The loop runs downward, so the lowest enabled lane with an edge wins.
  always_comb begin
    start = 1'b0;
    pick  = '0;
    for (int i = N_IN - 1; i >= 0; i--) begin
      if (lane_en[i] && fall[i]) begin
        start = armed;
        pick  = i[IW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sel_idx <= '0;
    else if (start) sel_idx <= pick;
  end

  assign line = lvl[sel_idx];

  // R1: ownership does not change while a frame is held.
  p_owner_held_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> $stable(sel_idx));
endmodule

// File: rtl/rc5_frame_dec.sv
module rc5_frame_dec
  import rc5_dec_pkg::*;
#(
  parameter int HALF_CYC = 404,
  localparam int S_MIN_I = HALF_CYC - HALF_CYC / 4,
  localparam int S_MAX_I = HALF_CYC + HALF_CYC / 4,
  localparam int L_MIN_I = 2 * HALF_CYC - HALF_CYC / 2,
  localparam int L_MAX_I = 2 * HALF_CYC + HALF_CYC / 2,
  localparam int QUIET_I = 8 * HALF_CYC,
  localparam int CW      = $clog2(QUIET_I + 2)
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      line,
  output logic      armed,
  output logic      valid,
  output rc5_word_t word
);
  localparam logic [CW-1:0] S_MIN = CW'(S_MIN_I);
  localparam logic [CW-1:0] S_MAX = CW'(S_MAX_I);
  localparam logic [CW-1:0] L_MIN = CW'(L_MIN_I);
  localparam logic [CW-1:0] L_MAX = CW'(L_MAX_I);
  localparam logic [CW-1:0] Q_END = CW'(QUIET_I - 1);

  dec_state_t          state;
  logic [CW-1:0]       cnt;
  logic [4:0]          nh;
  logic [HALVES-1:0]   hs;
  logic                line_q;
  logic                is_short, is_long, lvl_edge;
  logic [5:0]          nh_sum;
  logic [FRAME_BITS-1:0] bits;
  logic                pair_ok, frame_ok;

  assign lvl_edge = (line != line_q);
  assign is_short = (cnt >= S_MIN) && (cnt <= S_MAX);
  assign is_long  = (cnt >= L_MIN) && (cnt <= L_MAX);
  assign nh_sum   = {1'b0, nh} + (is_long ? 6'd2 : 6'd1);

  // Rebuild the bits from the half-bit levels.
  // The oldest half is at the top of hs; each cell needs a level change in its middle.
  always_comb begin
    pair_ok = 1'b1;
    bits    = '0;
    for (int i = 0; i < FRAME_BITS; i++) begin
      pair_ok = pair_ok & (hs[HALVES-1-2*i] ^ hs[HALVES-2-2*i]);
      bits[FRAME_BITS-1-i] = ~hs[HALVES-1-2*i];
    end
    frame_ok = pair_ok & bits[FRAME_BITS-1] & bits[FRAME_BITS-2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_ARMED;
      cnt    <= '0;
      nh     <= '0;
      hs     <= '0;
      line_q <= 1'b1;
      valid  <= 1'b0;
      word   <= '0;
    end else begin
      valid  <= 1'b0;
      line_q <= line;
      case (state)
        ST_ARMED: begin
          if (start) begin
            state  <= ST_RECV;
            cnt    <= CW'(1);
            nh     <= '0;
            line_q <= 1'b0;
          end
        end
        ST_RECV: begin
          if (lvl_edge) begin
            cnt <= CW'(1);
            if (!(is_short || is_long) || (nh_sum > 6'(HALVES))) begin
              state <= ST_QUIET;
              cnt   <= '0;
            end else begin
              hs <= is_long ? {hs[HALVES-3:0], line_q, line_q} : {hs[HALVES-2:0], line_q};
              nh <= nh_sum[4:0];
              if (nh_sum == 6'(HALVES)) state <= ST_CHECK;
            end
          end else if (cnt > L_MAX) begin
            if (line && (nh == 5'(HALVES - 1))) begin
              hs    <= {hs[HALVES-2:0], 1'b1};
              nh    <= 5'(HALVES);
              state <= ST_CHECK;
            end else begin
              state <= ST_QUIET;
              cnt   <= '0;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_CHECK: begin
          valid <= frame_ok;
          if (frame_ok) word <= bits[FRAME_BITS-3:0];
          state <= ST_QUIET;
          cnt   <= '0;
        end
        default: begin
          if (!line)            cnt   <= '0;
          else if (cnt >= Q_END) state <= ST_ARMED;
          else                  cnt   <= cnt + 1'b1;
        end
      endcase
    end
  end

  assign armed = (state == ST_ARMED);

  // R3: no more than 28 halves are ever gathered while receiving.
  p_half_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RECV) |-> (nh < 5'(HALVES)));
  // R7: a silent owner line cannot hold the receiver past the long window.
  p_stuck_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RECV) |-> (cnt <= L_MAX + 1'b1));
  // R8: a low owner line keeps the block from re-arming.
  p_quiet_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_QUIET && !line) |=> (state == ST_QUIET));
endmodule

// File: rtl/rc5_dual_decoder.sv
module rc5_dual_decoder
  import rc5_dec_pkg::*;
#(
  parameter int HALF_CYC = 404,
  parameter int SYNC_STG = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ir_a_n,
  input  logic       ir_b_n,
  input  logic       b_std_sel,
  output logic       word_valid,
  output logic       word_toggle,
  output logic [4:0] word_addr,
  output logic [5:0] word_cmd
);
  localparam int N_IN = 2;

  logic [N_IN-1:0] lvl, falls, lane_en;
  logic            start, line, dec_armed;
  logic [0:0]      sel_idx;
  rc5_word_t       word;

  assign lane_en = {b_std_sel, 1'b1};

  rc5_in_sync #(.N_IN(N_IN), .STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_n({ir_b_n, ir_a_n}), .lvl(lvl), .fall(falls)
  );

  rc5_arbiter #(.N_IN(N_IN)) u_arb (
    .clk(clk), .rst_n(rst_n), .armed(dec_armed), .lane_en(lane_en), .fall(falls),
    .lvl(lvl), .start(start), .sel_idx(sel_idx), .line(line)
  );

  rc5_frame_dec #(.HALF_CYC(HALF_CYC)) u_dec (
    .clk(clk), .rst_n(rst_n), .start(start), .line(line),
    .armed(dec_armed), .valid(word_valid), .word(word)
  );

  assign word_toggle = word.toggle;
  assign word_addr   = word.addr;
  assign word_cmd    = word.cmd;

  // R4: the strobe is never wider than one cycle.
  p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);
  // R2: a lone edge on a disabled line B leaves the block armed.
  p_b_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_armed && falls[1] && !falls[0] && !b_std_sel) |=> dec_armed);
endmodule

// File: tb/sim_rc5_dual_decoder.sv
`timescale 1ns/1ps
module sim_rc5_dual_decoder;
  localparam int HALF = 40;
  localparam int NV   = 10;
  localparam int GAP  = 1000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       a_n = 1'b1, b_n = 1'b1, bsel = 1'b1;
  logic       valid, tog;
  logic [4:0] addr;
  logic [5:0] cmd;

  int n_chk = 0, n_fail = 0, npulse = 0;
  logic [11:0] cap = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rc5_dual_decoder #(.HALF_CYC(HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .ir_a_n(a_n), .ir_b_n(b_n), .b_std_sel(bsel),
    .word_valid(valid), .word_toggle(tog), .word_addr(addr), .word_cmd(cmd)
  );

  always @(negedge clk) if (rst_n && valid) begin
    npulse++;
    cap = {tog, addr, cmd};
  end

  // Vector fields: [24] line, [23] b_std_sel, [22:21] start bits, [20] toggle,
  // [19:15] address, [14:9] command, [8:1] half length, [0] expect accept.
  localparam logic [24:0] VEC [NV] = '{
    {1'b0, 1'b1, 2'b11, 1'b1, 5'h05, 6'h23, 8'd40, 1'b1},  // R3 R4 basic frame on A
    {1'b1, 1'b1, 2'b11, 1'b1, 5'h1F, 6'h3F, 8'd40, 1'b1},  // R2 line B enabled
    {1'b1, 1'b0, 2'b11, 1'b0, 5'h0C, 6'h11, 8'd40, 1'b0},  // R2 line B disabled
    {1'b0, 1'b0, 2'b11, 1'b0, 5'h00, 6'h00, 8'd40, 1'b1},  // R3 zeros, ends on low half
    {1'b0, 1'b1, 2'b10, 1'b0, 5'h12, 6'h2A, 8'd40, 1'b0},  // R6 bad second start bit
    {1'b0, 1'b1, 2'b11, 1'b0, 5'h15, 6'h0A, 8'd32, 1'b1},  // R5 fast edge
    {1'b0, 1'b1, 2'b11, 1'b1, 5'h0A, 6'h35, 8'd48, 1'b1},  // R5 slow edge
    {1'b0, 1'b1, 2'b11, 1'b1, 5'h01, 6'h01, 8'd28, 1'b0},  // R5 too fast
    {1'b0, 1'b1, 2'b11, 1'b0, 5'h02, 6'h04, 8'd54, 1'b0},  // R5 gap between windows
    {1'b1, 1'b1, 2'b11, 1'b0, 5'h1A, 6'h19, 8'd40, 1'b1}   // R1 line B after all that
  };

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drv(input int idx, input logic v);
    if (idx == 0) a_n = v;
    else          b_n = v;
  endtask

  task automatic send(input int idx, input logic [1:0] st, input logic t,
                      input logic [4:0] a, input logic [5:0] c, input int hl);
    logic [13:0] w;
    w = {st, t, a, c};
    for (int i = 13; i >= 0; i--) begin
      drv(idx, ~w[i]); repeat (hl) @(negedge clk);
      drv(idx,  w[i]); repeat (hl) @(negedge clk);
    end
    drv(idx, 1'b1);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      finish_run();
    end
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(2);
    check(valid == 1'b0 && {tog, addr, cmd} == 12'd0, "R9 reset outputs",
          int'({valid, tog, addr, cmd}), 0);

    for (int k = 0; k < NV; k++) begin
      logic [24:0] v;
      v = VEC[k];
      bsel = v[23];
      npulse = 0;
      send(int'(v[24]), v[22:21], v[20], v[19:15], v[14:9], int'(v[8:1]));
      idle(GAP);
      check(npulse == int'(v[0]), $sformatf("R4 vector %0d strobe count", k), npulse, int'(v[0]));
      if (v[0]) check(cap == v[20:9], $sformatf("R3 vector %0d word", k), int'(cap), int'(v[20:9]));
    end

    // R1: A claims first and B overlaps it; only A's word comes out.
    bsel = 1'b1; npulse = 0;
    fork
      send(0, 2'b11, 1'b1, 5'h09, 6'h27, HALF);
      begin idle(3 * HALF); send(1, 2'b11, 1'b0, 5'h16, 6'h18, HALF); end
    join
    idle(GAP);
    check(npulse == 1 && cap == {1'b1, 5'h09, 6'h27}, "R1 A first", int'(cap), int'({1'b1, 5'h09, 6'h27}));

    // R1: B claims first; A overlaps it.
    npulse = 0;
    fork
      send(1, 2'b11, 1'b0, 5'h03, 6'h30, HALF);
      begin idle(3 * HALF); send(0, 2'b11, 1'b1, 5'h1C, 6'h07, HALF); end
    join
    idle(GAP);
    check(npulse == 1 && cap == {1'b0, 5'h03, 6'h30}, "R1 B first", int'(cap), int'({1'b0, 5'h03, 6'h30}));

    // R1: both lines fall in the same cycle; A wins.
    npulse = 0;
    fork
      send(0, 2'b11, 1'b0, 5'h11, 6'h2D, HALF);
      send(1, 2'b11, 1'b1, 5'h0E, 6'h12, HALF);
    join
    idle(GAP);
    check(npulse == 1 && cap == {1'b0, 5'h11, 6'h2D}, "R1 tie", int'(cap), int'({1'b0, 5'h11, 6'h2D}));

    // R8: a frame that starts 4 halves after the previous one is ignored.
    npulse = 0;
    send(0, 2'b11, 1'b0, 5'h0A, 6'h15, HALF);
    idle(4 * HALF);
    send(0, 2'b11, 1'b1, 5'h1E, 6'h3C, HALF);
    idle(GAP);
    check(npulse == 1 && cap == {1'b0, 5'h0A, 6'h15}, "R8 early frame ignored", npulse, 1);
    npulse = 0;
    send(0, 2'b11, 1'b1, 5'h07, 6'h0B, HALF);
    idle(GAP);
    check(npulse == 1 && cap == {1'b1, 5'h07, 6'h0B}, "R8 re-armed", int'(cap), int'({1'b1, 5'h07, 6'h0B}));

    // R7: the line held low too long aborts; a later frame still decodes.
    npulse = 0;
    a_n = 1'b0; idle(300); a_n = 1'b1;
    idle(GAP);
    check(npulse == 0, "R7 stuck low aborts", npulse, 0);
    send(0, 2'b11, 1'b0, 5'h13, 6'h26, HALF);
    idle(GAP);
    check(npulse == 1 && cap == {1'b0, 5'h13, 6'h26}, "R7 recovery", int'(cap), int'({1'b0, 5'h13, 6'h26}));

    // R4: between frames the strobe stays low and the word holds its value.
    check(valid == 1'b0 && {tog, addr, cmd} == {1'b0, 5'h13, 6'h26}, "R4 hold",
          int'({tog, addr, cmd}), int'({1'b0, 5'h13, 6'h26}));

    done = 1;
    finish_run();
  end
endmodule